// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port for fixed-length frames, acting as clock master. A host drives a small register bus to place bytes into a transmit holding register and to collect bytes from a receive holding register. A shift register behind each holding register moves one frame at a time. The serial clock comes from a fixed divider of the system clock.

Four status flags report the state of the port. One says the transmit holding register is empty. One says transmission has ended. One says a received byte is waiting. One says an overrun occurred. Accesses to the data registers clear the first three as a side effect. The overrun flag clears only when software writes it to zero. While it is set, the port stalls in both directions. Separate enable bits gate the transmitter and the receiver, and software can set both enables in one write.

Top module: `ssx_sync_port`

## Requirements
- R1: After reset the serial clock and the data output are high, the status byte (address 3) reads 0x03, and the control byte (address 2) reads 0x00. Status bits: bit0 = transmit buffer empty, bit1 = transmit ended, bit2 = receive data ready, bit3 = overrun.
- R2: A frame has 8 bits, sent least significant bit first. Each clock low and high phase lasts DIV system clocks. The data output changes only when the serial clock falls, and the data input is sampled when it rises.
- R3: A write to the transmit register (address 0) clears both the buffer-empty flag and the transmit-ended flag.
- R4: When a transmit frame starts, the transmit shift register is loaded from the buffer and the buffer-empty flag sets.
- R5: A byte written while the current frame is still shifting follows it with no gap: consecutive frame starts are exactly 16*DIV system clocks apart.
- R6: Transmit-ended sets when a transmit frame finishes and no byte is waiting. It stays clear while a byte is waiting.
- R7: When a received frame completes, it lands in the receive register (address 1) and sets receive-ready. Reading address 1 clears receive-ready.
- R8: If a frame completes while receive-ready is still set, the overrun flag sets, the receive register keeps its earlier byte, and the new frame is dropped.
- R9: While overrun is set, no frame starts and the serial clock stays high, even if transmit data is waiting. Writing the status register with bit3 = 0 clears overrun. Writing it with bit3 = 1 has no effect. Transfers resume after the flag clears.
- R10: Control bit0 enables transmit and bit1 enables receive, and both can be set in one write. With transmit enabled, the clock runs only while a byte is waiting. With only receive enabled, frames run back to back.
- R11: Clearing an enable bit during a frame lets that frame finish and starts no further one. The flags keep the values that frame gives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 transmit, 1 receive, 2 control, 3 status |
| bus_wdata | input | FRAME_W | Write data |
| bus_rdata | output | FRAME_W | Read data for the addressed register |
| sck_o | output | 1 | Serial clock, idle high |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |

## Verification
The bench goes after the joint between two frames. If the buffer-to-shift transfer were late by a cycle, the frame-start spacing would stretch past 16*DIV. If transmit-ended were raised while a byte was still waiting, it would read as set in the middle of a burst. Overrun is provoked with a third byte queued behind two unread frames. A design that wrote the dropped byte over the held one would return the wrong value on the next read. A design that kept clocking would let the queued byte out while the flag was still set. The bench also checks that a status write with bit3 high leaves overrun set, and that disabling the receiver mid-frame gives exactly one complete frame and then silence.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    typedef enum logic [1:0] {
        REG_TXBUF = 2'd0,
        REG_RXBUF = 2'd1,
        REG_CTRL  = 2'd2,
        REG_STAT  = 2'd3
    } reg_addr_e;

    localparam int OVR_BIT = 3;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    typedef struct packed {
        logic ovr;
        logic rx_full;
        logic tx_done;
        logic tx_empty;
    } stat_t;

    function automatic logic start_allowed(ctrl_t c, logic tx_empty, logic ovr_next);
        if (ovr_next) return 1'b0;
        if (c.tx_en)  return !tx_empty;
        return c.rx_en;
    endfunction

endpackage

// File: rtl/ssx_sck_gen.sv
module ssx_sck_gen #(
    parameter int DIV     = 4,
    parameter int FRAME_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_ok,
    output logic sck,
    output logic busy,
    output logic rise,
    output logic fall,
    output logic last,
    output logic start
);
    localparam int HALVES = 2 * FRAME_W;
    localparam int DW     = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HW     = $clog2(HALVES);

    logic [DW-1:0] div_q;
    logic [HW-1:0] half_q;
    logic          busy_q;
    logic          sck_q;
    logic          half_end;

    always_comb begin
        half_end = busy_q && (div_q == DW'(DIV - 1));
        rise     = half_end && !half_q[0];
        fall     = half_end && half_q[0] && (half_q != HW'(HALVES - 1));
        last     = half_end && (half_q == HW'(HALVES - 1));
    end

    assign start = start_ok && (!busy_q || last);
    assign sck   = sck_q;
    assign busy  = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b1;
            div_q  <= '0;
            half_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
            div_q  <= '0;
            half_q <= '0;
        end else if (busy_q) begin
            if (half_end) begin
                div_q <= '0;
                if (last) begin
                    busy_q <= 1'b0;
                end else begin
                    half_q <= half_q + HW'(1);
                    sck_q  <= ~sck_q;
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end
endmodule

// File: rtl/ssx_tx.sv
module ssx_tx #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               wr,
    input  logic [FRAME_W-1:0] wdata,
    input  logic               start,
    input  logic               fall,
    input  logic               last,
    output logic               txd,
    output logic               empty,
    output logic               done,
    output logic [FRAME_W-1:0] buf_q
);
    logic [FRAME_W-1:0] shreg;
    logic               active;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            shreg  <= '0;
            txd    <= 1'b1;
            empty  <= 1'b1;
            done   <= 1'b1;
            active <= 1'b0;
        end else begin
            if (start) begin
                active <= en;
                if (en) begin
                    shreg <= buf_q;
                    txd   <= buf_q[0];
                    empty <= 1'b1;
                    done  <= 1'b0;
                end
            end else if (fall && active) begin
                shreg <= shreg >> 1;
                txd   <= shreg[1];
            end
            if (last && active && empty && !wr)
                done <= 1'b1;
            if (wr) begin
                buf_q <= wdata;
                empty <= 1'b0;
                done  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ssx_rx.sv
module ssx_rx #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               rxd,
    input  logic               start,
    input  logic               rise,
    input  logic               last,
    input  logic               rd,
    input  logic               ovr_clr,
    output logic [FRAME_W-1:0] buf_q,
    output logic               full,
    output logic               ovr,
    output logic               ovr_next
);
    logic [FRAME_W-1:0] shreg;
    logic               active;
    logic               overrun;
    logic               store;

    always_comb begin
        overrun  = last && active && full && !rd;
        store    = last && active && !overrun;
        ovr_next = overrun || (ovr && !ovr_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            shreg  <= '0;
            full   <= 1'b0;
            ovr    <= 1'b0;
            active <= 1'b0;
        end else begin
            if (start)
                active <= en;
            if (rise && active)
                shreg <= {rxd, shreg[FRAME_W-1:1]};
            if (rd)
                full <= 1'b0;
            if (store) begin
                buf_q <= shreg;
                full  <= 1'b1;
            end
            ovr <= ovr_next;
        end
    end
endmodule

// File: rtl/ssx_sync_port.sv
module ssx_sync_port #(
    parameter int DIV     = 4,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [1:0]         bus_addr,
    input  logic [FRAME_W-1:0] bus_wdata,
    output logic [FRAME_W-1:0] bus_rdata,
    output logic               sck_o,
    output logic               txd_o,
    input  logic               rxd_i
);
    import ssx_pkg::*;

    ctrl_t              ctrl;
    stat_t              stat;
    logic               wr_tx, rd_rx, wr_ctrl, wr_stat, ovr_clr;
    logic               tx_empty, tx_done, rx_full, ovr, ovr_next;
    logic [FRAME_W-1:0] tx_buf, rx_buf;
    logic               start_ok, busy, rise, fall, last, start;

    always_comb begin
        wr_tx   = bus_sel &&  bus_we && (reg_addr_e'(bus_addr) == REG_TXBUF);
        rd_rx   = bus_sel && !bus_we && (reg_addr_e'(bus_addr) == REG_RXBUF);
        wr_ctrl = bus_sel &&  bus_we && (reg_addr_e'(bus_addr) == REG_CTRL);
        wr_stat = bus_sel &&  bus_we && (reg_addr_e'(bus_addr) == REG_STAT);
        ovr_clr = wr_stat && !bus_wdata[OVR_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr_ctrl)
            ctrl <= ctrl_t'(bus_wdata[1:0]);
    end

    assign start_ok = start_allowed(ctrl, tx_empty, ovr_next);

    ssx_sck_gen #(.DIV(DIV), .FRAME_W(FRAME_W)) u_sck (
        .clk(clk), .rst(rst), .start_ok(start_ok), .sck(sck_o), .busy(busy),
        .rise(rise), .fall(fall), .last(last), .start(start)
    );

    ssx_tx #(.FRAME_W(FRAME_W)) u_tx (
        .clk(clk), .rst(rst), .en(ctrl.tx_en), .wr(wr_tx), .wdata(bus_wdata),
        .start(start), .fall(fall), .last(last), .txd(txd_o),
        .empty(tx_empty), .done(tx_done), .buf_q(tx_buf)
    );

    ssx_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk(clk), .rst(rst), .en(ctrl.rx_en), .rxd(rxd_i), .start(start),
        .rise(rise), .last(last), .rd(rd_rx), .ovr_clr(ovr_clr),
        .buf_q(rx_buf), .full(rx_full), .ovr(ovr), .ovr_next(ovr_next)
    );

    always_comb begin
        stat = '{ovr: ovr, rx_full: rx_full, tx_done: tx_done, tx_empty: tx_empty};
        case (reg_addr_e'(bus_addr))
            REG_TXBUF: bus_rdata = tx_buf;
            REG_RXBUF: bus_rdata = rx_buf;
            REG_CTRL:  bus_rdata = FRAME_W'(ctrl);
            default:   bus_rdata = FRAME_W'(stat);
        endcase
    end
endmodule

// File: rtl/ssx_sync_port_chk.sv
module ssx_sync_port_chk #(
    parameter int FRAME_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               sck_o,
    input logic               txd_o,
    input logic               wr_tx,
    input logic               tx_empty,
    input logic               tx_done,
    input logic               rx_full,
    input logic               ovr,
    input logic [FRAME_W-1:0] rx_buf
);
    // R2
    txd_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd_o) |-> $fell(sck_o));

    // R3
    txwr_clears_chk: assert property (@(posedge clk) disable iff (rst)
        wr_tx |=> (!tx_empty && !tx_done));

    // R6
    done_implies_empty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> tx_empty);

    // R8
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> (rx_full && $stable(rx_buf)));

    // R8
    ovr_hold_buf_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && $past(ovr)) |-> $stable(rx_buf));

    // R9
    ovr_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && $past(ovr)) |-> (sck_o && $stable(sck_o)));
endmodule

bind ssx_sync_port ssx_sync_port_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk(clk), .rst(rst), .sck_o(sck_o), .txd_o(txd_o), .wr_tx(wr_tx),
    .tx_empty(tx_empty), .tx_done(tx_done), .rx_full(rx_full),
    .ovr(ovr), .rx_buf(rx_buf)
);

// File: tb/tb_ssx_sync_port.sv
module tb_ssx_sync_port;
    localparam int DIV = 4;
    localparam int FW  = 8;
    localparam int WD_LIMIT = 100000;

    localparam logic [1:0] A_TX = 2'd0, A_RX = 2'd1, A_CTRL = 2'd2, A_STAT = 2'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [1:0]    addr = '0;
    logic [FW-1:0] wdata = '0;
    logic [FW-1:0] rdata;
    logic          sck, txd;
    logic          rxd = 1'b1;

    always #2.5 clk = ~clk;

    ssx_sync_port #(.DIV(DIV), .FRAME_W(FW)) dut (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .sck_o(sck), .txd_o(txd), .rxd_i(rxd)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // behavioural slave and line model
    logic [7:0] exp_tx[$];
    logic [7:0] rx_src[$];
    int         starts[$];
    bit         chk_tx = 1'b1;
    int         frames = 0;
    int         t_fall = 0;
    int         nb = 0;
    logic       sck_prev = 1'b1, txd_prev = 1'b1;
    logic [7:0] cap = '0, cur = 8'hFF, expb;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            // R2: line data moves only with a falling clock
            checks++;
            if ((txd !== txd_prev) && !(sck_prev && !sck)) begin
                errors++;
                $display("FAIL R2 txd moved without falling sck: actual %b expected %b", txd, txd_prev);
            end
            if (sck_prev && !sck) begin
                t_fall = cyc;
                if (nb == 0) begin
                    starts.push_back(cyc);
                    cur = (rx_src.size() > 0) ? rx_src[0] : 8'hFF;
                end
                rxd = cur[nb];
            end
            if (!sck_prev && sck) begin
                chk("R2 low phase width", cyc - t_fall, DIV);
                cap[nb] = txd;
                nb++;
                if (nb == FW) begin
                    nb = 0;
                    frames++;
                    if (rx_src.size() > 0) void'(rx_src.pop_front());
                    if (chk_tx) begin
                        expb = (exp_tx.size() > 0) ? exp_tx.pop_front() : 8'hxx;
                        chk("R2 serial byte LSB first", cap, expb);
                    end
                end
            end
        end
        sck_prev = sck;
        txd_prev = txd;
        if (cyc > WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic wait_stat(input int b, input logic val);
        logic [7:0] v;
        bit ok = 1'b0;
        for (int i = 0; i < 500 && !ok; i++) begin
            rd(A_STAT, v);
            if (v[b] === val) ok = 1'b1;
        end
        chk("R4 status poll reached", ok, 1);
    endtask

    task automatic wait_frames(input int n);
        while (frames < n) @(negedge clk);
        repeat (DIV + 2) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        int f0, s0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 sck idle", sck, 1);
        chk("R1 txd idle", txd, 1);
        rd(A_STAT, v); chk("R1 status", v, 8'h03);
        rd(A_CTRL, v); chk("R1 control", v, 8'h00);

        // transmit only
        wr(A_CTRL, 8'h01);
        exp_tx.push_back(8'hA5);
        wr(A_TX, 8'hA5);
        rd(A_STAT, v); chk("R3 write clears empty and done", v, 8'h00);
        rd(A_STAT, v); chk("R4 load sets empty", v[1:0], 2'b01);
        wait_frames(1);
        rd(A_STAT, v); chk("R6 done after last frame", v, 8'h03);
        f0 = frames;
        repeat (60) @(negedge clk);
        chk("R10 no clock without tx data", frames, f0);
        chk("R10 sck parked high", sck, 1);

        // full duplex, back to back
        wr(A_CTRL, 8'h03);
        rd(A_CTRL, v); chk("R10 both enables in one write", v, 8'h03);
        exp_tx.push_back(8'h3C); exp_tx.push_back(8'h81);
        rx_src.push_back(8'h5A); rx_src.push_back(8'hC3);
        f0 = frames; s0 = starts.size();
        wr(A_TX, 8'h3C);
        wait_stat(0, 1'b1);
        wr(A_TX, 8'h81);
        wait_frames(f0 + 1);
        rd(A_RX, v); chk("R7 first received byte", v, 8'h5A);
        rd(A_STAT, v); chk("R6 R7 done low while data waits, read clears ready", v, 8'h01);
        wait_frames(f0 + 2);
        chk("R5 no gap between frames", starts[s0 + 1] - starts[s0], 16 * DIV);
        rd(A_RX, v); chk("R7 second received byte", v, 8'hC3);
        rd(A_STAT, v); chk("R6 idle status after burst", v, 8'h03);

        // overrun
        exp_tx.push_back(8'h11); exp_tx.push_back(8'h33); exp_tx.push_back(8'h55);
        rx_src.push_back(8'h22); rx_src.push_back(8'h44); rx_src.push_back(8'h66);
        f0 = frames;
        wr(A_TX, 8'h11);
        wait_stat(0, 1'b1);
        wr(A_TX, 8'h33);
        wait_stat(0, 1'b1);
        wr(A_TX, 8'h55);
        wait_frames(f0 + 2);
        repeat (60) @(negedge clk);
        rd(A_STAT, v); chk("R8 overrun flagged with data pending", v, 8'h0C);
        chk("R9 no frame while overrun", frames, f0 + 2);
        chk("R9 sck high while overrun", sck, 1);
        wr(A_STAT, 8'h08);
        rd(A_STAT, v); chk("R9 writing bit3 high keeps overrun", v[3], 1);
        rd(A_RX, v); chk("R8 earlier byte kept", v, 8'h22);
        repeat (40) @(negedge clk);
        chk("R9 still frozen after data read", frames, f0 + 2);
        wr(A_STAT, 8'h00);
        rd(A_STAT, v); chk("R9 bit3 low clears overrun", v[3], 0);
        wait_frames(f0 + 3);
        rd(A_RX, v); chk("R9 transfer resumes after clear", v, 8'h66);

        // receive only, enable dropped mid-frame
        chk_tx = 1'b0;
        rx_src.push_back(8'h96);
        f0 = frames;
        wr(A_CTRL, 8'h02);
        repeat (20) @(negedge clk);
        wr(A_CTRL, 8'h00);
        wait_frames(f0 + 1);
        repeat (60) @(negedge clk);
        chk("R11 exactly one frame after disable", frames, f0 + 1);
        rd(A_STAT, v); chk("R11 flags from completed frame kept", v, 8'h07);
        rd(A_RX, v); chk("R10 R11 receive-only frame data", v, 8'h96);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule